// File: doc/BRIEF.md
# Priority Throttle Arbiter

This block sits between a set of hardware throttle sources (for example a mild thermal alarm, a severe thermal alarm and an overcurrent alarm) and the clock throttlers of the CPU and GPU. Each source is a simple on/off request. Alongside it come a programmed priority, a CPU pulse-skip depth in percent and a GPU throttle level code. On every clock the arbiter looks at the sources that are requesting and picks the one with the largest priority. It then forwards that source's CPU depth and GPU level together, as one settings pair, so the two clock domains never mix values from different sources.

The outputs are registered and follow the request flags with one cycle of latency. They are level-type control outputs that the throttlers sample continuously. There is therefore no ready signal and no back-pressure: a new selection simply replaces the old one on the next edge. A priority of zero marks a source as switched off. Out-of-range priorities and depths are clamped, so a mis-programmed source can never produce a depth above 100%.

Top module: `thr_arb`

## Requirements
- R1: While reset is asserted and on the first sample after it, the outputs are CPU depth 0, GPU level 0 (none) and valid low.
- R2: When no eligible source is requesting, the next cycle shows CPU depth 0, GPU level 0 and valid low.
- R3: Among eligible requesting sources, the one with the numerically largest priority supplies both the CPU depth and the GPU level.
- R4: When two or more eligible requesting sources share the largest priority, the one with the lowest index wins.
- R5: Outputs are registered: a change on any input appears on the outputs after exactly one rising clock edge, and not before it.
- R6: A source whose priority is 0 is never selected, even while its request flag is high.
- R7: A priority above 100 is treated as 100, so it ties with a source programmed to 100 and the tie rule of R4 applies.
- R8: A CPU depth above 100 is forwarded as 100; depths from 0 to 100 pass unchanged.
- R9: The GPU level is a 2-bit code (0 none, 1 low/50%, 2 medium/75%, 3 high/85%) that is passed from the winning source unchanged.
- R10: Valid is high exactly when at least one requesting source had a non-zero priority at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | NSRC | Per-source on/off throttle request |
| src_prio | input | NSRC*PRIO_W | Per-source priority, source i at bits [i*PRIO_W +: PRIO_W] |
| src_depth | input | NSRC*DEPTH_W | Per-source CPU skip depth in percent, source i at bits [i*DEPTH_W +: DEPTH_W] |
| src_level | input | NSRC*2 | Per-source GPU level code, source i at bits [i*2 +: 2] |
| thr_cpu_depth | output | DEPTH_W | Selected CPU skip depth in percent |
| thr_gpu_level | output | 2 | Selected GPU level code |
| thr_valid | output | 1 | At least one eligible source is selected |

## Verification
The hardest case to reach from the ports is a tie. In a tie, several sources request at once with equal priorities, and some of those equal values only come about through clamping: a priority of 127 must lose to a lower-indexed 100. Disabled sources that still request are similar. The stimulus sweeps every request mask against every combination of a small priority alphabet (0, 1, 50, 100, 127) on all three sources, which produces every tie, clamp and disable pattern. Depths and level codes rotate per case so that a winner taken from the wrong source shows up in its depth, its level or both.

// File: rtl/thr_arb_pkg.sv
package thr_arb_pkg;
  localparam int unsigned PRIO_CEIL  = 100;
  localparam int unsigned DEPTH_CEIL = 100;
  localparam int unsigned LVL_W      = 2;

  typedef enum logic [LVL_W-1:0] {
    GLVL_NONE = 2'd0,
    GLVL_LOW  = 2'd1,
    GLVL_MED  = 2'd2,
    GLVL_HIGH = 2'd3
  } gpu_lvl_e;
endpackage

// File: rtl/thr_arb_qualify.sv
module thr_arb_qualify
  import thr_arb_pkg::*;
#(
  parameter int PRIO_W  = 7,
  parameter int DEPTH_W = 7
) (
  input  logic               req_i,
  input  logic [PRIO_W-1:0]  prio_i,
  input  logic [DEPTH_W-1:0] depth_i,
  input  logic [LVL_W-1:0]   level_i,
  output logic               elig_o,
  output logic [PRIO_W-1:0]  prio_o,
  output logic [DEPTH_W-1:0] depth_o,
  output gpu_lvl_e           level_o
);
  localparam logic [PRIO_W-1:0]  PCAP = PRIO_W'(PRIO_CEIL);
  localparam logic [DEPTH_W-1:0] DCAP = DEPTH_W'(DEPTH_CEIL);

  always_comb begin
    elig_o  = req_i && (prio_i != '0);
    prio_o  = (prio_i > PCAP) ? PCAP : prio_i;
    depth_o = (depth_i > DCAP) ? DCAP : depth_i;
    level_o = gpu_lvl_e'(level_i);
  end
endmodule

// File: rtl/thr_arb_select.sv
module thr_arb_select
  import thr_arb_pkg::*;
#(
  parameter int NSRC    = 3,
  parameter int PRIO_W  = 7,
  parameter int DEPTH_W = 7
) (
  input  logic [NSRC-1:0]               elig_i,
  input  logic [NSRC-1:0][PRIO_W-1:0]   prio_i,
  input  logic [NSRC-1:0][DEPTH_W-1:0]  depth_i,
  input  gpu_lvl_e                      level_i [NSRC],
  output logic                          any_o,
  output logic [DEPTH_W-1:0]            depth_o,
  output gpu_lvl_e                      level_o
);
  logic [PRIO_W-1:0] best;

  // Strict greater-than while scanning upward keeps the lowest index on ties.
  always_comb begin
    best    = '0;
    any_o   = 1'b0;
    depth_o = '0;
    level_o = GLVL_NONE;
    for (int i = 0; i < NSRC; i++) begin
      if (elig_i[i] && (!any_o || prio_i[i] > best)) begin
        any_o   = 1'b1;
        best    = prio_i[i];
        depth_o = depth_i[i];
        level_o = level_i[i];
      end
    end
  end
endmodule

// File: rtl/thr_arb_hold.sv
module thr_arb_hold
  import thr_arb_pkg::*;
#(
  parameter int DEPTH_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               any_i,
  input  logic [DEPTH_W-1:0] depth_i,
  input  gpu_lvl_e           level_i,
  output logic [DEPTH_W-1:0] depth_o,
  output gpu_lvl_e           level_o,
  output logic               valid_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_o <= '0;
      level_o <= GLVL_NONE;
      valid_o <= 1'b0;
    end else begin
      depth_o <= any_i ? depth_i : '0;
      level_o <= any_i ? level_i : GLVL_NONE;
      valid_o <= any_i;
    end
  end
endmodule

// File: rtl/thr_arb.sv
module thr_arb
  import thr_arb_pkg::*;
#(
  parameter int NSRC    = 3,
  parameter int PRIO_W  = 7,
  parameter int DEPTH_W = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSRC-1:0]           src_req,
  input  logic [NSRC*PRIO_W-1:0]    src_prio,
  input  logic [NSRC*DEPTH_W-1:0]   src_depth,
  input  logic [NSRC*LVL_W-1:0]     src_level,
  output logic [DEPTH_W-1:0]        thr_cpu_depth,
  output logic [LVL_W-1:0]          thr_gpu_level,
  output logic                      thr_valid
);
  logic [NSRC-1:0]              q_elig;
  logic [NSRC-1:0][PRIO_W-1:0]  q_prio;
  logic [NSRC-1:0][DEPTH_W-1:0] q_depth;
  gpu_lvl_e                     q_level [NSRC];

  logic               sel_any;
  logic [DEPTH_W-1:0] sel_depth;
  gpu_lvl_e           sel_level;
  gpu_lvl_e           out_level;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    thr_arb_qualify #(.PRIO_W(PRIO_W), .DEPTH_W(DEPTH_W)) u_qual (
      .req_i   (src_req[g]),
      .prio_i  (src_prio[g*PRIO_W +: PRIO_W]),
      .depth_i (src_depth[g*DEPTH_W +: DEPTH_W]),
      .level_i (src_level[g*LVL_W +: LVL_W]),
      .elig_o  (q_elig[g]),
      .prio_o  (q_prio[g]),
      .depth_o (q_depth[g]),
      .level_o (q_level[g])
    );
  end

  thr_arb_select #(.NSRC(NSRC), .PRIO_W(PRIO_W), .DEPTH_W(DEPTH_W)) u_sel (
    .elig_i  (q_elig),
    .prio_i  (q_prio),
    .depth_i (q_depth),
    .level_i (q_level),
    .any_o   (sel_any),
    .depth_o (sel_depth),
    .level_o (sel_level)
  );

  thr_arb_hold #(.DEPTH_W(DEPTH_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .any_i   (sel_any),
    .depth_i (sel_depth),
    .level_i (sel_level),
    .depth_o (thr_cpu_depth),
    .level_o (out_level),
    .valid_o (thr_valid)
  );

  assign thr_gpu_level = out_level;
endmodule

// File: rtl/thr_arb_chk.sv
module thr_arb_chk #(
  parameter int NSRC    = 3,
  parameter int PRIO_W  = 7,
  parameter int DEPTH_W = 7
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NSRC-1:0]         src_req,
  input logic [NSRC*PRIO_W-1:0]  src_prio,
  input logic [NSRC*DEPTH_W-1:0] src_depth,
  input logic [NSRC*2-1:0]       src_level,
  input logic [DEPTH_W-1:0]      thr_cpu_depth,
  input logic [1:0]              thr_gpu_level,
  input logic                    thr_valid
);
  logic [NSRC-1:0] live;
  for (genvar g = 0; g < NSRC; g++) begin : g_live
    assign live[g] = src_req[g] && (src_prio[g*PRIO_W +: PRIO_W] != '0);
  end

  logic [NSRC*(1+PRIO_W+DEPTH_W+2)-1:0] ins;
  assign ins = {src_req, src_prio, src_depth, src_level};

  // R2: an idle output carries zero depth and the none level
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !thr_valid |-> (thr_cpu_depth == '0 && thr_gpu_level == 2'd0));

  // R8: the forwarded depth never exceeds 100 percent
  a_r8_depth_cap: assert property (@(posedge clk) disable iff (!rst_n)
    thr_cpu_depth <= DEPTH_W'(100));

  // R10: valid tracks whether any live request existed one edge earlier
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (thr_valid == $past(|live)));

  // R5: inputs held over two edges leave the outputs unchanged
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2) && $past(ins) == $past(ins, 2))
      |-> ($stable(thr_cpu_depth) && $stable(thr_gpu_level) && $stable(thr_valid)));

  // R6: with every requester at priority zero nothing is selected
  a_r6_zero_prio_off: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(live) == '0) |-> !thr_valid);
endmodule

bind thr_arb thr_arb_chk #(.NSRC(NSRC), .PRIO_W(PRIO_W), .DEPTH_W(DEPTH_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .src_req       (src_req),
  .src_prio      (src_prio),
  .src_depth     (src_depth),
  .src_level     (src_level),
  .thr_cpu_depth (thr_cpu_depth),
  .thr_gpu_level (thr_gpu_level),
  .thr_valid     (thr_valid)
);

// File: tb/thr_arb_test.sv
`timescale 1ns/1ps
module thr_arb_test;
  localparam int NS = 3;
  localparam int PW = 7;
  localparam int DW = 7;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NS-1:0]     src_req = '0;
  logic [NS*PW-1:0]  src_prio = '0;
  logic [NS*DW-1:0]  src_depth = '0;
  logic [NS*2-1:0]   src_level = '0;
  logic [DW-1:0]     thr_cpu_depth;
  logic [1:0]        thr_gpu_level;
  logic              thr_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  thr_arb #(.NSRC(NS), .PRIO_W(PW), .DEPTH_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_prio(src_prio),
    .src_depth(src_depth), .src_level(src_level),
    .thr_cpu_depth(thr_cpu_depth), .thr_gpu_level(thr_gpu_level), .thr_valid(thr_valid)
  );

  task automatic check3(string tag, int ed, int el, int ev);
    checks++;
    if (int'(thr_cpu_depth) != ed || int'(thr_gpu_level) != el || int'(thr_valid) != ev) begin
      fails++;
      $display("FAIL %s: got depth=%0d level=%0d valid=%0d, expected depth=%0d level=%0d valid=%0d",
               tag, thr_cpu_depth, thr_gpu_level, thr_valid, ed, el, ev);
    end
  endtask

  int pal [5] = '{0, 1, 50, 100, 127};

  initial begin
    int ed, el, ev, bestp, wi;
    bit tie, clampw, satw, offreq;
    string tag;
    repeat (3) @(negedge clk);
    check3("R1 during reset", 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check3("R1 after reset", 0, 0, 0);

    for (int k = 0; k < 1000; k++) begin
      int p [NS];
      int d [NS];
      int l [NS];
      int a;
      a = k % 8;
      p[0] = pal[(k / 8) % 5];
      p[1] = pal[(k / 40) % 5];
      p[2] = pal[(k / 200) % 5];
      for (int i = 0; i < NS; i++) begin
        d[i] = (17 * k + 45 * i) % 128;
        l[i] = (k + i) % 4;
        src_prio[i*PW +: PW]  = PW'(p[i]);
        src_depth[i*DW +: DW] = DW'(d[i]);
        src_level[i*2 +: 2]   = 2'(l[i]);
      end
      src_req = NS'(a);
      // expected: clamp, scan for max with lowest index on ties
      bestp = 0; wi = -1; tie = 0; offreq = 0;
      for (int i = 0; i < NS; i++) begin
        int cp;
        cp = (p[i] > 100) ? 100 : p[i];
        if (a[i] && p[i] == 0) offreq = 1;
        if (a[i] && p[i] != 0) begin
          if (cp > bestp) begin bestp = cp; wi = i; tie = 0; end
          else if (cp == bestp) tie = 1;
        end
      end
      if (wi < 0) begin
        ed = 0; el = 0; ev = 0;
        tag = offreq ? "R6 zero priority ignored" : "R2 idle output";
      end else begin
        ed = (d[wi] > 100) ? 100 : d[wi];
        el = l[wi];
        ev = 1;
        clampw = (p[wi] > 100);
        satw   = (d[wi] > 100);
        if (tie && bestp == 100) tag = "R7 clamped priority tie";
        else if (tie)            tag = "R4 lowest index on tie";
        else if (satw)           tag = "R8 depth saturation";
        else if (clampw)         tag = "R7 clamped priority";
        else                     tag = "R3 R9 highest priority vector";
      end
      // R5: nothing changes before the edge
      if (k % 50 == 1) begin
        int od, ol, ov;
        od = int'(thr_cpu_depth); ol = int'(thr_gpu_level); ov = int'(thr_valid);
        #1;
        check3("R5 no change before edge", od, ol, ov);
      end
      @(posedge clk);
      @(negedge clk);
      check3(tag, ed, el, ev);
      if (k % 100 == 0) begin
        checks++;
        if (int'(thr_valid) != ((wi >= 0) ? 1 : 0)) begin
          fails++;
          $display("FAIL R10: valid=%0d expected=%0d", thr_valid, (wi >= 0));
        end
      end
    end

    // R2: drop all requests after an active case
    src_req = '0;
    @(posedge clk); @(negedge clk);
    check3("R2 all requests dropped", 0, 0, 0);
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule